// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits between the decimating core of a two-channel converter and the output pins. The core hands over one two's-complement sample per channel on each output-rate strobe. The formatter recodes both samples into the selected output code and flags samples that are clipped or too large. It then presents the data either on two parallel buses or, when the decimation setting allows, time-multiplexed on bus A. A generated data clock frames the data for the receiver.

A strobe arrives every `STROBE_DIV` clock cycles, and `STROBE_DIV` is a multiple of 4. The data clock is built from that period. It has one cycle per sample in two-bus mode and two cycles per sample in multiplexed mode. The block latches all configuration inputs on the strobe, so a change between strobes takes effect with the next sample.

Top module: `adc_out_fmt`

## Requirements
- R1: Code select `2'b00` gives offset binary: the output equals the raw sample with its most significant bit inverted.
- R2: Code select `2'b01` and `2'b11` give the raw two's-complement sample unchanged.
- R3: Code select `2'b10` gives Gray code: offset binary XOR (offset binary shifted right by one), so a raw zero gives `16'hC000`.
- R4: In two-bus mode, the strobe edge loads `bus_a` with channel A and `bus_b` with channel B and drives `dco` low. `dco` goes high `STROBE_DIV/2` cycles later. The buses change only on strobe edges.
- R5: Multiplexed mode is in force when `mux_req` is 1, `dec_whole` is 1 and `dec_ratio` > 8. With Q = `STROBE_DIV/4`, at strobe-relative edges 0 and 2Q `bus_a` carries channel A and `dco` goes high. At edges Q and 3Q it carries channel B and `dco` goes low.
- R6: While multiplexed mode is in force, `bus_b` is all zeros.
- R7: `dco_flip` = 1 inverts `dco` in both modes and leaves the data order on the buses unchanged.
- R8: A multiplexing request with `dec_ratio` <= 8 or `dec_whole` = 0 leaves the block in two-bus mode and sets `mux_refused`. Otherwise `mux_refused` is 0.
- R9: An overrange flag is set for a sample equal to `16'h7FFF` or `16'h8000`, or whose magnitude exceeds the unsigned `ovr_limit`. The flag updates only on strobe edges.
- R10: Overrange detection uses the raw sample, so the code select does not change it.
- R11: After reset, all outputs are zero.
- R12: Configuration inputs take effect only at a strobe. Changing them between strobes does not change the outputs until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Output-rate strobe, one cycle every STROBE_DIV cycles |
| smp_a | input | 16 | Channel A sample, two's complement |
| smp_b | input | 16 | Channel B sample, two's complement |
| code_sel | input | 2 | Output code select |
| mux_req | input | 1 | Request to multiplex both channels onto bus A |
| dco_flip | input | 1 | Invert the data clock |
| dec_whole | input | 1 | 1 when the decimation factor is an integer |
| dec_ratio | input | 8 | Integer part of the decimation factor |
| ovr_limit | input | 16 | Unsigned magnitude threshold for overrange |
| bus_a | output | 16 | Output bus A |
| bus_b | output | 16 | Output bus B |
| dco | output | 1 | Generated data clock |
| ovr_a | output | 1 | Channel A overrange flag |
| ovr_b | output | 1 | Channel B overrange flag |
| mux_refused | output | 1 | Multiplexing request refused for this sample |

## Verification
Several properties are checked on every cycle. `bus_b` stays grounded while multiplexing is active. A refused request never coexists with multiplexed mode. The overrange flags and the two-bus outputs hold between strobes. Full-scale clip codes always raise a flag.

The code conversions, the slot timing of `dco` against the multiplexed data, the inversion, the threshold edge (limit versus limit+1) and the latching of configuration changed between strobes depend on sequences of values. Only the bench's scenarios, compared against its behavioural model, can show them.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    localparam int SMP_W         = 16;
    localparam int RATIO_W       = 8;
    localparam int MUX_MIN_RATIO = 8;

    typedef enum logic [1:0] {
        CODE_OFFBIN = 2'b00,
        CODE_TWOS   = 2'b01,
        CODE_GRAY   = 2'b10,
        CODE_TWOS2  = 2'b11
    } code_e;

    typedef struct packed {
        logic mux;
        logic flip;
    } mode_t;

    function automatic logic mux_legal(input logic req, input logic whole,
                                       input logic [RATIO_W-1:0] ratio);
        return req && whole && (ratio > RATIO_W'(MUX_MIN_RATIO));
    endfunction

endpackage

// File: rtl/adc_code_enc.sv
module adc_code_enc
    import adc_fmt_pkg::*;
#(
    parameter int W = SMP_W
) (
    input  logic [W-1:0] raw,
    input  code_e        sel,
    output logic [W-1:0] coded
);
    logic [W-1:0] obin;

    always_comb begin
        obin = {~raw[W-1], raw[W-2:0]};
        unique case (sel)
            CODE_OFFBIN: coded = obin;
            CODE_GRAY:   coded = obin ^ (obin >> 1);
            default:     coded = raw;
        endcase
    end
endmodule

// File: rtl/adc_ovr_det.sv
module adc_ovr_det
    import adc_fmt_pkg::*;
#(
    parameter int W = SMP_W
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W:0] mag;
    logic       clip;

    always_comb begin
        mag  = raw[W-1] ? ({1'b0, ~raw} + (W+1)'(1)) : {1'b0, raw};
        clip = (raw == {1'b0, {(W-1){1'b1}}}) || (raw == {1'b1, {(W-1){1'b0}}});
        hit  = clip || (mag > {1'b0, limit});
    end
endmodule

// File: rtl/adc_slot_seq.sv
module adc_slot_seq #(
    parameter int STROBE_DIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    output logic       slot_ev,
    output logic [1:0] slot_idx
);
    localparam int CW = $clog2(STROBE_DIV + 1);
    localparam int Q  = STROBE_DIV / 4;
    localparam logic [CW-1:0] Q1  = CW'(Q);
    localparam logic [CW-1:0] Q2  = CW'(2 * Q);
    localparam logic [CW-1:0] Q3  = CW'(3 * Q);
    localparam logic [CW-1:0] TOP = CW'(STROBE_DIV);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= TOP;
        end else if (stb) begin
            cnt_q <= CW'(1);
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        slot_ev  = !stb && ((cnt_q == Q1) || (cnt_q == Q2) || (cnt_q == Q3));
        slot_idx = (cnt_q == Q1) ? 2'd1 : (cnt_q == Q2) ? 2'd2 : 2'd3;
    end
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
    import adc_fmt_pkg::*;
#(
    parameter int STROBE_DIV = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_vld,
    input  logic [SMP_W-1:0]   smp_a,
    input  logic [SMP_W-1:0]   smp_b,
    input  logic [1:0]         code_sel,
    input  logic               mux_req,
    input  logic               dco_flip,
    input  logic               dec_whole,
    input  logic [RATIO_W-1:0] dec_ratio,
    input  logic [SMP_W-1:0]   ovr_limit,
    output logic [SMP_W-1:0]   bus_a,
    output logic [SMP_W-1:0]   bus_b,
    output logic               dco,
    output logic               ovr_a,
    output logic               ovr_b,
    output logic               mux_refused
);
    localparam int NCH = 2;

    logic [NCH-1:0][SMP_W-1:0] raw;
    logic [NCH-1:0][SMP_W-1:0] coded;
    logic [NCH-1:0][SMP_W-1:0] hold_q;
    logic [NCH-1:0]            hit;
    logic [NCH-1:0]            ovr_q;
    logic [SMP_W-1:0]          bus_a_q, bus_b_q;
    logic                      dco_q, refused_q, legal;
    mode_t                     mode_q;
    logic                      slot_ev;
    logic [1:0]                slot_idx;

    assign raw[0] = smp_a;
    assign raw[1] = smp_b;
    assign legal  = mux_legal(mux_req, dec_whole, dec_ratio);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        adc_code_enc #(.W(SMP_W)) u_enc (
            .raw   (raw[ch]),
            .sel   (code_e'(code_sel)),
            .coded (coded[ch])
        );
        adc_ovr_det #(.W(SMP_W)) u_ovr (
            .raw   (raw[ch]),
            .limit (ovr_limit),
            .hit   (hit[ch])
        );
    end

    adc_slot_seq #(.STROBE_DIV(STROBE_DIV)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_vld),
        .slot_ev  (slot_ev),
        .slot_idx (slot_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            ovr_q     <= '0;
            bus_a_q   <= '0;
            bus_b_q   <= '0;
            dco_q     <= 1'b0;
            refused_q <= 1'b0;
            mode_q    <= '0;
        end else if (smp_vld) begin
            hold_q    <= coded;
            ovr_q     <= hit;
            refused_q <= mux_req && !legal;
            mode_q    <= '{mux: legal, flip: dco_flip};
            bus_a_q   <= coded[0];
            bus_b_q   <= legal ? '0 : coded[1];
            dco_q     <= legal ? !dco_flip : dco_flip;
        end else if (slot_ev) begin
            if (mode_q.mux) begin
                bus_a_q <= slot_idx[0] ? hold_q[1] : hold_q[0];
                dco_q   <= !slot_idx[0] ^ mode_q.flip;
            end else if (slot_idx == 2'd2) begin
                dco_q   <= !mode_q.flip;
            end
        end
    end

    assign bus_a       = bus_a_q;
    assign bus_b       = bus_b_q;
    assign dco         = dco_q;
    assign ovr_a       = ovr_q[0];
    assign ovr_b       = ovr_q[1];
    assign mux_refused = refused_q;
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        smp_vld,
    input logic [15:0] smp_a,
    input logic [15:0] bus_a,
    input logic [15:0] bus_b,
    input logic        ovr_a,
    input logic        ovr_b,
    input logic        mux_refused,
    input logic        mode_mux
);
    AST_BUSB_GROUNDED: assert property (@(posedge clk) disable iff (rst)
        mode_mux |-> (bus_b == 16'h0000)); // R6

    AST_REFUSED_TWO_BUS: assert property (@(posedge clk) disable iff (rst)
        mux_refused |-> !mode_mux); // R8

    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_vld) |-> ($stable(ovr_a) && $stable(ovr_b))); // R9

    AST_CLIP_FLAG: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && smp_vld && (smp_a == 16'h7FFF || smp_a == 16'h8000)) |-> ovr_a); // R9

    AST_TWO_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mode_mux && !$past(smp_vld)) |-> ($stable(bus_a) && $stable(bus_b))); // R4
endmodule

bind adc_out_fmt adc_out_fmt_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_vld     (smp_vld),
    .smp_a       (smp_a),
    .bus_a       (bus_a),
    .bus_b       (bus_b),
    .ovr_a       (ovr_a),
    .ovr_b       (ovr_b),
    .mux_refused (mux_refused),
    .mode_mux    (mode_q.mux)
);

// File: tb/sim_adc_out_fmt.sv
module sim_adc_out_fmt;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int QS         = DIV / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_a = '0, smp_b = '0;
    logic [1:0]  code_sel = 2'b00;
    logic        mux_req = 1'b0, dco_flip = 1'b0, dec_whole = 1'b1;
    logic [7:0]  dec_ratio = 8'd16;
    logic [15:0] ovr_limit = 16'h7FFF;
    logic [15:0] bus_a, bus_b;
    logic        dco, ovr_a, ovr_b, mux_refused;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_out_fmt #(.STROBE_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_a(smp_a), .smp_b(smp_b),
        .code_sel(code_sel), .mux_req(mux_req), .dco_flip(dco_flip),
        .dec_whole(dec_whole), .dec_ratio(dec_ratio), .ovr_limit(ovr_limit),
        .bus_a(bus_a), .bus_b(bus_b), .dco(dco), .ovr_a(ovr_a), .ovr_b(ovr_b),
        .mux_refused(mux_refused)
    );

    int    total = 0, bad = 0;
    string tag = "R11";
    bit    done = 0, begun = 0;
    int    seed = 7;

    // reference model state
    logic [15:0] e_a = '0, e_b = '0, h_a = '0, h_b = '0;
    logic        e_dco = 0, e_ova = 0, e_ovb = 0, e_ref = 0, m_mux = 0, m_flip = 0;
    int          ph = DIV;

    function automatic logic [15:0] ref_code(logic [15:0] x, logic [1:0] f);
        logic [15:0] ob, g;
        ob = 16'((int'(x) + 32768) % 65536);
        if (f == 2'b00) return ob;
        if (f == 2'b10) begin
            g[15] = ob[15];
            for (int i = 14; i >= 0; i--) g[i] = ob[i] ^ ob[i+1];
            return g;
        end
        return x;
    endfunction

    function automatic logic ref_ovr(logic [15:0] x, logic [15:0] lim);
        int v, m;
        v = int'($signed(x));
        m = (v < 0) ? -v : v;
        return (v == 32767) || (v == -32768) || (m > int'(lim));
    endfunction

    always @(posedge clk) begin
        begun = 1;
        if (rst) begin
            e_a = '0; e_b = '0; h_a = '0; h_b = '0; e_dco = 0;
            e_ova = 0; e_ovb = 0; e_ref = 0; m_mux = 0; m_flip = 0; ph = DIV;
        end else if (smp_vld) begin
            m_mux  = mux_req && dec_whole && (dec_ratio > 8);
            m_flip = dco_flip;
            e_ref  = mux_req && !m_mux;
            h_a    = ref_code(smp_a, code_sel);
            h_b    = ref_code(smp_b, code_sel);
            e_ova  = ref_ovr(smp_a, ovr_limit);
            e_ovb  = ref_ovr(smp_b, ovr_limit);
            ph     = 0;
            e_a    = h_a;
            e_b    = m_mux ? 16'h0000 : h_b;
            e_dco  = m_mux ? !m_flip : m_flip;
        end else begin
            if (ph < DIV) ph++;
            if (ph == QS || ph == 2*QS || ph == 3*QS) begin
                if (m_mux) begin
                    e_a   = ((ph / QS) % 2 == 1) ? h_b : h_a;
                    e_dco = ((ph / QS) % 2 == 1) ? m_flip : !m_flip;
                end else if (ph == 2*QS) begin
                    e_dco = !m_flip;
                end
            end
        end
    end

    task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (begun && !done && !rst) begin
            chk(tag, "bus_a", 32'(bus_a), 32'(e_a));
            chk(tag, "bus_b", 32'(bus_b), 32'(e_b));
            chk(tag, "dco", 32'(dco), 32'(e_dco));
            chk(tag, "ovr_a", 32'(ovr_a), 32'(e_ova));
            chk(tag, "ovr_b", 32'(ovr_b), 32'(e_ovb));
            chk(tag, "mux_refused", 32'(mux_refused), 32'(e_ref));
        end
    end

    task automatic next_rand(output logic [15:0] v);
        seed = seed * 1103515245 + 12345;
        v = seed[30:15];
    endtask

    task automatic sample(logic [15:0] a, logic [15:0] b);
        @(negedge clk);
        smp_vld = 1'b1; smp_a = a; smp_b = b;
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (DIV - 2) @(negedge clk);
    endtask

    task automatic rand_samples(int n);
        logic [15:0] a, b;
        for (int i = 0; i < n; i++) begin
            next_rand(a); next_rand(b);
            sample(a, b);
        end
    endtask

    // changes configuration between strobes; must not disturb the current sample
    task automatic sample_midcfg(logic [15:0] a, logic [15:0] b);
        @(negedge clk);
        smp_vld = 1'b1; smp_a = a; smp_b = b;
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
        code_sel = ~code_sel; mux_req = ~mux_req; dco_flip = ~dco_flip;
        ovr_limit = 16'h0000;
        repeat (DIV - 3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R11";
        chk("R11", "bus_a", 32'(bus_a), 0);
        chk("R11", "bus_b", 32'(bus_b), 0);
        chk("R11", "dco", 32'(dco), 0);
        chk("R11", "ovr", 32'({ovr_a, ovr_b, mux_refused}), 0);
        rst = 1'b0;

        tag = "R1"; code_sel = 2'b00;
        sample(16'h7FFF, 16'h8000); sample(16'h0000, 16'hFFFF);
        rand_samples(4);
        tag = "R4"; rand_samples(3);

        tag = "R2"; code_sel = 2'b01; rand_samples(4);
        code_sel = 2'b11; sample(16'h1234, 16'hEDCC); rand_samples(2);

        tag = "R3"; code_sel = 2'b10;
        sample(16'h0000, 16'h0001);
        chk("R3", "gray of zero", 32'(bus_a), 32'h0000C000);
        rand_samples(4);

        tag = "R9"; code_sel = 2'b00; ovr_limit = 16'd1000;
        sample(16'd1001, 16'd1000); sample(16'hFC17, 16'hFC18);
        chk("R9", "ovr pair", 32'({ovr_a, ovr_b}), 32'b10);
        tag = "R10"; code_sel = 2'b10;
        sample(16'd1001, 16'd1000); sample(16'h7FFF, 16'd5);
        ovr_limit = 16'h7FFF;

        tag = "R5"; mux_req = 1'b1; dec_whole = 1'b1; dec_ratio = 8'd16; code_sel = 2'b01;
        sample(16'hAAAA, 16'h5555); rand_samples(4);
        tag = "R6";
        chk("R6", "bus_b grounded", 32'(bus_b), 0);

        tag = "R7"; dco_flip = 1'b1; rand_samples(3);
        mux_req = 1'b0; rand_samples(3);
        dco_flip = 1'b0;

        tag = "R8"; mux_req = 1'b1; dec_ratio = 8'd8;
        sample(16'h0101, 16'h0202);
        chk("R8", "refused at ratio 8", 32'(mux_refused), 1);
        dec_ratio = 8'd12; dec_whole = 1'b0; rand_samples(2);
        dec_ratio = 8'd9; dec_whole = 1'b1;
        sample(16'h0303, 16'h0404);
        chk("R8", "accepted at ratio 9", 32'(mux_refused), 0);

        tag = "R12"; mux_req = 1'b0; code_sel = 2'b00; ovr_limit = 16'h7FFF;
        sample_midcfg(16'h0010, 16'h0020);
        sample_midcfg(16'h0030, 16'h0040);
        sample_midcfg(16'hF000, 16'h0F00);

        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule